// File: doc/BRIEF.md
# Pin Function Multiplexer Register Bank

This block holds the per-pin configuration of one 32-pin port. For every pin it records the owner of the pin: the general-purpose I/O controller, or one of four internal peripheral functions. It also keeps the pin's pad settings, which are the pull-up, the pull-down and the input hysteresis (Schmitt) bypass. The analog pad, the output data path and interrupt logic read these settings from the block's outputs. They are built elsewhere.

Software writes the bank over a simple synchronous bus with a byte address, write data, a write strobe and combinational read data. Pin ownership and both pull resistors use paired set and clear offsets with a status readback: a 1 in the written word acts on that pin, and a 0 leaves the pin as it was. The peripheral choice is spread over two plain read/write select words, each supplying one bit of the 2-bit code for a pin. The Schmitt bypass word is also plain read/write. The block never lets a pin have its pull-up and pull-down active together.

Top module: `pmux_bank`

## Requirements
- R1: When the reset synchroniser releases, every pin is owned by the GPIO controller (`pin_gpio_own` all ones), both select words and `pin_func` are zero, all pull-ups are on, all pull-downs are off and the Schmitt bypass word is zero.
- R2: Writing to offset 0x04 gives each pin whose data bit is 1 to its peripheral (the ownership bit becomes 0). Writing to offset 0x00 gives each such pin back to GPIO (the bit becomes 1). Offset 0x08 reads the ownership word. Data bits that are 0 leave their pins unchanged.
- R3: Offset 0x30 (low select word) and offset 0x34 (high select word) are read/write. `pin_func[2i+1:2i]` is {high[i], low[i]}, so 00 selects function A, 01 selects B, 10 selects C and 11 selects D.
- R4: A write to offset 0x10 sets the pull-up of each pin whose data bit is 1. A write to offset 0x14 clears it. Offset 0x18 reads the pull-up word.
- R5: A write to offset 0x20 sets the pull-down of each pin whose data bit is 1. A write to offset 0x24 clears it. Offset 0x28 reads the pull-down word.
- R6: Setting a pin's pull-down clears its pull-up in the same cycle, and setting its pull-up clears its pull-down. No pin ever has both active.
- R7: Offset 0x40 is read/write, and a 1 in bit i bypasses the Schmitt trigger of pin i (`pad_schmitt_off[i]`).
- R8: Reads of any other offset, of the set/clear offsets, or of an address whose two low bits are not zero return 0. Writes to any address that is not one of the nine writable offsets change no state.
- R9: A write takes effect at the clock edge on which `bus_we` is high. Outputs and read data show the new value from the following cycle. `bus_rdata` follows `bus_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW (8) | Byte address |
| bus_wdata | input | NPINS (32) | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | NPINS (32) | Read data for `bus_addr` |
| pin_gpio_own | output | NPINS (32) | 1 = pin owned by GPIO controller |
| pin_func | output | 2*NPINS (64) | Per-pin peripheral code {high, low} |
| pad_pullup | output | NPINS (32) | Pull-up enables |
| pad_pulldown | output | NPINS (32) | Pull-down enables |
| pad_schmitt_off | output | NPINS (32) | Schmitt bypass per pin |

## Verification
Every configuration result comes from a single register stage. A write held through one rising edge is therefore due on the outputs and on readback at the next falling edge. The bench drives a write on a falling edge and lowers the strobe on the next falling edge. It compares all five output words and one readback there, against its model updated for that write. Read data is combinational. A read is checked 1 ns after the address changes on a falling edge, with no clock edge in between. The reset values are checked only after the two-stage reset synchroniser has had several edges to release.

// File: rtl/pmux_pkg.sv
package pmux_pkg;

  // Byte offsets of the register map
  localparam int unsigned OFF_OWN_GPIO   = 32'h00;
  localparam int unsigned OFF_OWN_PERIPH = 32'h04;
  localparam int unsigned OFF_OWN_STAT   = 32'h08;
  localparam int unsigned OFF_PU_SET     = 32'h10;
  localparam int unsigned OFF_PU_CLR     = 32'h14;
  localparam int unsigned OFF_PU_STAT    = 32'h18;
  localparam int unsigned OFF_PD_SET     = 32'h20;
  localparam int unsigned OFF_PD_CLR     = 32'h24;
  localparam int unsigned OFF_PD_STAT    = 32'h28;
  localparam int unsigned OFF_SEL_LO     = 32'h30;
  localparam int unsigned OFF_SEL_HI     = 32'h34;
  localparam int unsigned OFF_SCHMITT    = 32'h40;

  localparam int unsigned MIN_AW = 7;

  typedef enum logic [3:0] {
    REG_NONE,
    REG_OWN_GPIO,
    REG_OWN_PERIPH,
    REG_OWN_STAT,
    REG_PU_SET,
    REG_PU_CLR,
    REG_PU_STAT,
    REG_PD_SET,
    REG_PD_CLR,
    REG_PD_STAT,
    REG_SEL_LO,
    REG_SEL_HI,
    REG_SCHMITT
  } pmux_reg_e;

endpackage

// File: rtl/pmux_rst_sync.sv
module pmux_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/pmux_decode.sv
module pmux_decode
  import pmux_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic [AW-1:0] addr_i,
  output pmux_reg_e     reg_o
);
  always_comb begin
    reg_o = REG_NONE;
    if (addr_i == AW'(OFF_OWN_GPIO))   reg_o = REG_OWN_GPIO;
    if (addr_i == AW'(OFF_OWN_PERIPH)) reg_o = REG_OWN_PERIPH;
    if (addr_i == AW'(OFF_OWN_STAT))   reg_o = REG_OWN_STAT;
    if (addr_i == AW'(OFF_PU_SET))     reg_o = REG_PU_SET;
    if (addr_i == AW'(OFF_PU_CLR))     reg_o = REG_PU_CLR;
    if (addr_i == AW'(OFF_PU_STAT))    reg_o = REG_PU_STAT;
    if (addr_i == AW'(OFF_PD_SET))     reg_o = REG_PD_SET;
    if (addr_i == AW'(OFF_PD_CLR))     reg_o = REG_PD_CLR;
    if (addr_i == AW'(OFF_PD_STAT))    reg_o = REG_PD_STAT;
    if (addr_i == AW'(OFF_SEL_LO))     reg_o = REG_SEL_LO;
    if (addr_i == AW'(OFF_SEL_HI))     reg_o = REG_SEL_HI;
    if (addr_i == AW'(OFF_SCHMITT))    reg_o = REG_SCHMITT;
  end
endmodule

// File: rtl/pmux_field.sv
module pmux_field #(
  parameter int unsigned N       = 32,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [N-1:0] xclr_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_r;
  logic [N-1:0] q_nx;
  logic         upd_en;

  // next-state
  always_comb begin
    upd_en = set_i | clr_i | wr_i | (|xclr_i);
    q_nx   = wr_i ? d_i : q_r;
    if (set_i) q_nx = q_nx | d_i;
    if (clr_i) q_nx = q_nx & ~d_i;
    q_nx = q_nx & ~xclr_i;
  end

  // register with explicit enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_r <= RST_VAL;
    end else if (upd_en) begin
      q_r <= q_nx;
    end
  end

  assign q_o = q_r;

  // R2 R4 R5: a set write raises every selected bit
  w1s_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i && !wr_i) |=>
      ((q_o & $past(d_i & ~xclr_i)) == $past(d_i & ~xclr_i)));

  // R2 R4 R5: a clear write drops every selected bit
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((q_o & $past(d_i)) == '0));

  // R6: a cross-clear from the opposite pull drops those bits
  xclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|xclr_i) |=> ((q_o & $past(xclr_i)) == '0));

  // R3 R7: a plain write loads the word
  rw_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !set_i && !clr_i && (xclr_i == '0)) |=> (q_o == $past(d_i)));

  // R8: no request, no change
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i && !wr_i && (xclr_i == '0)) |=> $stable(q_o));
endmodule

// File: rtl/pmux_bank.sv
module pmux_bank
  import pmux_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned AW    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic [NPINS-1:0]   bus_wdata,
  input  logic               bus_we,
  output logic [NPINS-1:0]   bus_rdata,
  output logic [NPINS-1:0]   pin_gpio_own,
  output logic [2*NPINS-1:0] pin_func,
  output logic [NPINS-1:0]   pad_pullup,
  output logic [NPINS-1:0]   pad_pulldown,
  output logic [NPINS-1:0]   pad_schmitt_off
);
  localparam logic [NPINS-1:0] ALL_ONES = {NPINS{1'b1}};
  localparam logic [NPINS-1:0] ALL_ZERO = {NPINS{1'b0}};
  localparam int unsigned      NSTB     = 9;

  logic      rst_int_n;
  pmux_reg_e reg_id;

  logic stb_own_gpio, stb_own_periph;
  logic stb_pu_set, stb_pu_clr, stb_pd_set, stb_pd_clr;
  logic stb_sel_lo, stb_sel_hi, stb_schmitt;
  logic [NSTB-1:0] stb_vec;

  logic [NPINS-1:0] pu_xclr, pd_xclr;
  logic [NPINS-1:0] own_q, pu_q, pd_q, lo_q, hi_q, st_q;

  pmux_rst_sync u_rst (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .rst_sync_no(rst_int_n)
  );

  pmux_decode #(.AW(AW)) u_dec (
    .addr_i(bus_addr),
    .reg_o (reg_id)
  );

  // write strobes
  always_comb begin
    stb_own_gpio   = bus_we && (reg_id == REG_OWN_GPIO);
    stb_own_periph = bus_we && (reg_id == REG_OWN_PERIPH);
    stb_pu_set     = bus_we && (reg_id == REG_PU_SET);
    stb_pu_clr     = bus_we && (reg_id == REG_PU_CLR);
    stb_pd_set     = bus_we && (reg_id == REG_PD_SET);
    stb_pd_clr     = bus_we && (reg_id == REG_PD_CLR);
    stb_sel_lo     = bus_we && (reg_id == REG_SEL_LO);
    stb_sel_hi     = bus_we && (reg_id == REG_SEL_HI);
    stb_schmitt    = bus_we && (reg_id == REG_SCHMITT);
    stb_vec = {stb_own_gpio, stb_own_periph, stb_pu_set, stb_pu_clr,
               stb_pd_set, stb_pd_clr, stb_sel_lo, stb_sel_hi, stb_schmitt};
    // pull exclusion: setting one side clears the other
    pu_xclr = stb_pd_set ? bus_wdata : ALL_ZERO;
    pd_xclr = stb_pu_set ? bus_wdata : ALL_ZERO;
  end

  pmux_field #(.N(NPINS), .RST_VAL(ALL_ONES)) u_own (
    .clk_i(clk), .rst_ni(rst_int_n),
    .set_i(stb_own_gpio), .clr_i(stb_own_periph), .wr_i(1'b0),
    .xclr_i(ALL_ZERO), .d_i(bus_wdata), .q_o(own_q)
  );

  pmux_field #(.N(NPINS), .RST_VAL(ALL_ONES)) u_pu (
    .clk_i(clk), .rst_ni(rst_int_n),
    .set_i(stb_pu_set), .clr_i(stb_pu_clr), .wr_i(1'b0),
    .xclr_i(pu_xclr), .d_i(bus_wdata), .q_o(pu_q)
  );

  pmux_field #(.N(NPINS), .RST_VAL(ALL_ZERO)) u_pd (
    .clk_i(clk), .rst_ni(rst_int_n),
    .set_i(stb_pd_set), .clr_i(stb_pd_clr), .wr_i(1'b0),
    .xclr_i(pd_xclr), .d_i(bus_wdata), .q_o(pd_q)
  );

  pmux_field #(.N(NPINS), .RST_VAL(ALL_ZERO)) u_sel_lo (
    .clk_i(clk), .rst_ni(rst_int_n),
    .set_i(1'b0), .clr_i(1'b0), .wr_i(stb_sel_lo),
    .xclr_i(ALL_ZERO), .d_i(bus_wdata), .q_o(lo_q)
  );

  pmux_field #(.N(NPINS), .RST_VAL(ALL_ZERO)) u_sel_hi (
    .clk_i(clk), .rst_ni(rst_int_n),
    .set_i(1'b0), .clr_i(1'b0), .wr_i(stb_sel_hi),
    .xclr_i(ALL_ZERO), .d_i(bus_wdata), .q_o(hi_q)
  );

  pmux_field #(.N(NPINS), .RST_VAL(ALL_ZERO)) u_schmitt (
    .clk_i(clk), .rst_ni(rst_int_n),
    .set_i(1'b0), .clr_i(1'b0), .wr_i(stb_schmitt),
    .xclr_i(ALL_ZERO), .d_i(bus_wdata), .q_o(st_q)
  );

  // per-pin function code {high, low}
  for (genvar i = 0; i < NPINS; i++) begin : g_func
    assign pin_func[2*i]   = lo_q[i];
    assign pin_func[2*i+1] = hi_q[i];
  end

  assign pin_gpio_own    = own_q;
  assign pad_pullup      = pu_q;
  assign pad_pulldown    = pd_q;
  assign pad_schmitt_off = st_q;

  // status readback
  always_comb begin
    case (reg_id)
      REG_OWN_STAT: bus_rdata = own_q;
      REG_PU_STAT:  bus_rdata = pu_q;
      REG_PD_STAT:  bus_rdata = pd_q;
      REG_SEL_LO:   bus_rdata = lo_q;
      REG_SEL_HI:   bus_rdata = hi_q;
      REG_SCHMITT:  bus_rdata = st_q;
      default:      bus_rdata = ALL_ZERO;
    endcase
  end

  initial begin
    if (AW < MIN_AW) $error("address width too small for the register map");
  end

  // R8: at most one register is written per cycle
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(stb_vec));

  // R6
  pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((pad_pullup & pad_pulldown) == '0));

  // R8
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_id == REG_NONE) |-> (bus_rdata == '0));

  // R8
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_we && (reg_id == REG_NONE)) |=>
      ($stable(pin_gpio_own) && $stable(pin_func) && $stable(pad_pullup) &&
       $stable(pad_pulldown) && $stable(pad_schmitt_off)));

  // R3: select changes leave ownership alone
  sel_own_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stb_sel_lo || stb_sel_hi) |=> $stable(pin_gpio_own));
endmodule

// File: tb/sim_pmux_bank.sv
module sim_pmux_bank;
  localparam int NP = 32;
  localparam int AWB = 8;

  logic            clk;
  logic            rst_n;
  logic [AWB-1:0]  bus_addr;
  logic [NP-1:0]   bus_wdata;
  logic            bus_we;
  logic [NP-1:0]   bus_rdata;
  logic [NP-1:0]   pin_gpio_own;
  logic [2*NP-1:0] pin_func;
  logic [NP-1:0]   pad_pullup;
  logic [NP-1:0]   pad_pulldown;
  logic [NP-1:0]   pad_schmitt_off;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // model
  logic [NP-1:0] m_own, m_pu, m_pd, m_lo, m_hi, m_st;

  pmux_bank #(.NPINS(NP), .AW(AWB)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_gpio_own(pin_gpio_own),
    .pin_func(pin_func), .pad_pullup(pad_pullup), .pad_pulldown(pad_pulldown),
    .pad_schmitt_off(pad_schmitt_off)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  function automatic logic [2*NP-1:0] exp_func(logic [NP-1:0] lo, logic [NP-1:0] hi);
    logic [2*NP-1:0] f;
    for (int i = 0; i < NP; i++) begin
      f[2*i]   = lo[i];
      f[2*i+1] = hi[i];
    end
    return f;
  endfunction

  function automatic logic [NP-1:0] exp_read(logic [7:0] a);
    case (a)
      8'h08: return m_own;
      8'h18: return m_pu;
      8'h28: return m_pd;
      8'h30: return m_lo;
      8'h34: return m_hi;
      8'h40: return m_st;
      default: return '0;
    endcase
  endfunction

  function automatic void model_write(logic [7:0] a, logic [NP-1:0] d);
    case (a)
      8'h00: m_own = m_own | d;
      8'h04: m_own = m_own & ~d;
      8'h10: begin m_pu = m_pu | d; m_pd = m_pd & ~d; end
      8'h14: m_pu = m_pu & ~d;
      8'h20: begin m_pd = m_pd | d; m_pu = m_pu & ~d; end
      8'h24: m_pd = m_pd & ~d;
      8'h30: m_lo = d;
      8'h34: m_hi = d;
      8'h40: m_st = d;
      default: ;
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_outputs(string req);
    chk({req, " own"}, 64'(pin_gpio_own), 64'(m_own));
    chk({req, " func"}, pin_func, exp_func(m_lo, m_hi));
    chk({req, " pullup"}, 64'(pad_pullup), 64'(m_pu));
    chk({req, " pulldown"}, 64'(pad_pulldown), 64'(m_pd));
    chk({req, " schmitt"}, 64'(pad_schmitt_off), 64'(m_st));
    chk("R6 exclusive pulls", 64'(pad_pullup & pad_pulldown), 64'd0);
  endtask

  // drive on falling edge, result due at the next falling edge (R9)
  task automatic wr(logic [7:0] a, logic [NP-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd_chk(string req, logic [7:0] a);
    bus_addr = a;
    #1;
    chk(req, 64'(bus_rdata), 64'(exp_read(a)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] map [12] = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h18,
                             8'h20, 8'h24, 8'h28, 8'h30, 8'h34, 8'h40};
    void'($urandom(32'h1234_5eed));
    rst_n = 0; bus_addr = '0; bus_wdata = '0; bus_we = 0;
    m_own = '1; m_pu = '1; m_pd = '0; m_lo = '0; m_hi = '0; m_st = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk_outputs("R1 reset");
    foreach (map[k]) rd_chk("R1 reset readback", map[k]);

    // R2 ownership
    wr(8'h04, 32'hFFFF_0000);
    chk_outputs("R2 give to peripheral");
    rd_chk("R2 ownership status", 8'h08);
    wr(8'h00, 32'h0001_0000);
    chk_outputs("R2 give back to gpio");
    wr(8'h04, 32'h0);
    chk_outputs("R2 zero data no effect");
    rd_chk("R2 write-only offset reads zero", 8'h04);

    // R3 select encodings A,B,C,D on pins 0..3
    wr(8'h30, 32'h0000_000A);
    wr(8'h34, 32'h0000_000C);
    chk("R3 pin func codes", 64'(pin_func[7:0]), 64'h0000_0000_0000_00E4);
    chk_outputs("R3 select");
    rd_chk("R3 select low readback", 8'h30);
    rd_chk("R3 select high readback", 8'h34);

    // R4 R5 R6 pulls
    wr(8'h14, 32'h0000_00FF);
    chk_outputs("R4 pull-up clear");
    wr(8'h20, 32'h0000_0F0F);
    chk_outputs("R5 R6 pull-down set clears pull-up");
    wr(8'h10, 32'h0000_0003);
    chk_outputs("R4 R6 pull-up set clears pull-down");
    wr(8'h24, 32'h0000_0100);
    chk_outputs("R5 pull-down clear");
    rd_chk("R4 pull-up status", 8'h18);
    rd_chk("R5 pull-down status", 8'h28);

    // R7 schmitt
    wr(8'h40, 32'h8000_0001);
    chk_outputs("R7 schmitt bypass");
    rd_chk("R7 schmitt readback", 8'h40);

    // R8 unmapped and misaligned
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h31, 32'hFFFF_FFFF);
    wr(8'h44, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    chk_outputs("R8 ignored writes");
    rd_chk("R8 unmapped read", 8'h0C);
    rd_chk("R8 misaligned read", 8'h19);
    rd_chk("R8 high unmapped read", 8'hFC);

    // R9 random mix
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      logic [NP-1:0] d;
      if (($urandom % 8) == 0) a = 8'($urandom);
      else a = map[$urandom % 12];
      d = $urandom;
      wr(a, d);
      chk_outputs("R9 random write");
      rd_chk("R9 random readback", map[$urandom % 12]);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule